// File: doc/BRIEF.md
# Neural Link-Utilization Threshold Predictor

This block turns a burst of per-link utilization samples from one 4×4 region of an on-chip network into the utilization threshold for the next power-management interval. It holds up to eight 8-bit samples, each tagged with a slot index. It starts an evaluation once every slot has been filled in the current burst, or once a fixed number of cycles has passed since the first sample of the burst, whichever comes first. Slots with no sample in the burst count as zero.

The predictor is a fixed-point feed-forward network. It has eight inputs, four hidden neurons and one output neuron. All coefficients are signed 6-bit values, and every neuron has its own bias. One multiply-accumulate unit evaluates the whole network, one product per cycle. Each neuron's sum passes through a saturating piecewise-linear sigmoid that gives an 8-bit value. The threshold appears on the output with a one-cycle strobe. Pretrained coefficients are written through a simple address/data port. A write that arrives during an evaluation is held back until the evaluation is over.

Top module: `nn_thresh_pred`

## Requirements
- R1: After reset, thr_vld is 0, thr_val is 0 and every coefficient is zero. With all coefficients zero, an evaluation returns 128.
- R2: A sample is accepted on a clock edge where util_vld is 1. util_sel gives the slot (0..7) and util_val gives the unsigned value. The evaluation starts on the edge that fills the last empty slot of the burst, and thr_vld is high after the 36th rising edge that follows.
- R3: If TIMEOUT edges have passed since the first accepted sample of a burst, the evaluation starts even if some slots are still empty. Those slots count as 0, and thr_vld is high after the 36th edge that follows.
- R4: Hidden neuron j computes s = 256·b_j + Σ_i w_{j,i}·u_i. Its output is clamp(floor(s/32) + 128, 0, 255).
- R5: The threshold is the same activation applied to 256·c + Σ_j v_j·a_j, where a_j are the hidden outputs, v_j the output weights and c the output bias.
- R6: Coefficients are signed 6-bit two's complement values. The address map is: j·8+i for w_{j,i}, 32+j for b_j, 36+j for v_j, and 40 for c. Writes to addresses above 40 are ignored.
- R7: thr_vld is high for exactly one cycle per evaluation. thr_val keeps its value until the next strobe.
- R8: Samples offered while an evaluation is running are dropped and do not appear in any later burst.
- R9: A coefficient write accepted during an evaluation does not affect that evaluation. It takes effect in the first cycle after the evaluation. Only the most recent deferred write is kept.
- R10: After each evaluation, all slots are cleared and the timeout is disarmed until a new sample arrives.
- R11: If a slot receives more than one sample in a burst, the last value received is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| util_vld | input | 1 | Utilization sample strobe |
| util_sel | input | 3 | Slot index of the sample |
| util_val | input | 8 | Unsigned utilization value |
| wgt_we | input | 1 | Coefficient write strobe |
| wgt_addr | input | 6 | Coefficient address |
| wgt_data | input | 6 | Signed coefficient value |
| thr_vld | output | 1 | One-cycle strobe marking a new threshold |
| thr_val | output | 8 | Predicted threshold, held between strobes |

## Verification
A full burst ends on the edge that fills the last slot, and the threshold is due on the 36th rising edge after that edge. A burst that relies on the timeout has its threshold due TIMEOUT + 36 edges after its first sample. The bench counts rising edges from the edge that accepts the relevant sample. It reads the outputs one time unit after each edge and compares the edge count at which the strobe appears with these exact numbers. It then checks on the next edge that the strobe has dropped and the value is held. Expected thresholds come from an integer model of the network that runs over sweeps of coefficient sets, including both saturation extremes, and of input patterns.

// File: rtl/nn_pkg.sv
package nn_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EVAL    = 1'b1
  } phase_t;
endpackage

// File: rtl/nn_collect.sv
// Gathers one burst of samples and decides when evaluation begins.
module nn_collect #(
  parameter int N_IN    = 8,
  parameter int UW      = 8,
  parameter int TIMEOUT = 64,
  localparam int IW     = $clog2(N_IN),
  localparam int TW     = $clog2(TIMEOUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              clr,
  input  logic              u_valid,
  input  logic [IW-1:0]     u_idx,
  input  logic [UW-1:0]     u_data,
  output logic              start,
  output logic [N_IN*UW-1:0] in_flat
);
  logic [UW-1:0] vals_q [N_IN];
  logic [UW-1:0] vals_d [N_IN];
  logic [N_IN-1:0] mask_q, mask_d, sel;
  logic armed_q, armed_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic acc_ok, tout;

  always_comb begin
    acc_ok = u_valid && !busy;
    sel    = acc_ok ? (N_IN'(1) << u_idx) : '0;
    tout   = armed_q && (tmr_q == TW'(TIMEOUT - 1));
    start  = !busy && ((acc_ok && (&(mask_q | sel))) || tout);
  end

  always_comb begin
    vals_d  = vals_q;
    mask_d  = mask_q;
    armed_d = armed_q;
    tmr_d   = tmr_q;
    if (clr) begin
      for (int k = 0; k < N_IN; k++) vals_d[k] = '0;
      mask_d  = '0;
      armed_d = 1'b0;
      tmr_d   = '0;
    end else if (!busy) begin
      if (armed_q && !start) tmr_d = tmr_q + 1'b1;
      if (acc_ok) begin
        for (int k = 0; k < N_IN; k++)
          if (u_idx == IW'(k)) vals_d[k] = u_data;
        mask_d  = mask_q | sel;
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_IN; k++) vals_q[k] <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      vals_q  <= vals_d;
      mask_q  <= mask_d;
      armed_q <= armed_d;
      tmr_q   <= tmr_d;
    end
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_flat
    assign in_flat[g*UW +: UW] = vals_q[g];
  end
endmodule

// File: rtl/nn_wstore.sv
// Coefficient register file with a one-entry hold for writes during evaluation.
module nn_wstore #(
  parameter int NW = 41,
  parameter int WW = 6,
  localparam int AW = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WW-1:0]    wr_data,
  output logic [NW*WW-1:0] w_flat
);
  logic [WW-1:0] mem_q [NW];
  logic [WW-1:0] mem_d [NW];
  logic          pend_v_q, pend_v_d;
  logic [AW-1:0] pend_a_q, pend_a_d;
  logic [WW-1:0] pend_w_q, pend_w_d;
  logic          addr_ok;

  always_comb begin
    addr_ok  = int'(wr_addr) < NW;
    mem_d    = mem_q;
    pend_v_d = pend_v_q;
    pend_a_d = pend_a_q;
    pend_w_d = pend_w_q;
    if (pend_v_q && !busy) begin
      for (int k = 0; k < NW; k++)
        if (pend_a_q == AW'(k)) mem_d[k] = pend_w_q;
      pend_v_d = 1'b0;
    end
    if (wr_en && addr_ok) begin
      if (busy) begin
        pend_v_d = 1'b1;
        pend_a_d = wr_addr;
        pend_w_d = wr_data;
      end else begin
        for (int k = 0; k < NW; k++)
          if (wr_addr == AW'(k)) mem_d[k] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) mem_q[k] <= '0;
      pend_v_q <= 1'b0;
      pend_a_q <= '0;
      pend_w_q <= '0;
    end else begin
      mem_q    <= mem_d;
      pend_v_q <= pend_v_d;
      pend_a_q <= pend_a_d;
      pend_w_q <= pend_w_d;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign w_flat[g*WW +: WW] = mem_q[g];
  end
endmodule

// File: rtl/nn_seq.sv
// Sequential network evaluation on one shared multiply-accumulate unit.
module nn_seq
  import nn_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_HID  = 4,
  parameter int UW     = 8,
  parameter int WW     = 6,
  parameter int ACT_SH = 5,
  localparam int NW    = N_IN*N_HID + 2*N_HID + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_IN*UW-1:0] in_flat,
  input  logic [NW*WW-1:0]   w_flat,
  output logic               busy,
  output logic               done,
  output logic               thr_vld,
  output logic [UW-1:0]      thr_val
);
  localparam int HB    = N_IN*N_HID;
  localparam int OWB   = HB + N_HID;
  localparam int OB    = OWB + N_HID;
  localparam int CW    = $clog2(N_IN > N_HID ? N_IN : N_HID);
  localparam int HCW   = $clog2(N_HID + 1);
  localparam int HIW   = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int ACC_W = UW + WW + $clog2(N_IN + N_HID + 1) + 2;
  localparam logic signed [ACC_W-1:0] MID  = ACC_W'(1) <<< (UW - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< UW) - 1;

  function automatic logic [UW-1:0] act(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] t;
    t = (s >>> ACT_SH) + MID;
    if (t < 0)         return '0;
    else if (t > MAXV) return '1;
    else               return t[UW-1:0];
  endfunction

  phase_t phase_q, phase_d;
  logic [CW-1:0]  cnt_i_q, cnt_i_d;
  logic [HCW-1:0] cnt_h_q, cnt_h_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [UW-1:0] hid_q [N_HID];
  logic [UW-1:0] hid_d [N_HID];
  logic [UW-1:0] thr_q, thr_d;
  logic          vld_q, vld_d;

  logic out_layer, first, last;
  int   waddr, baddr;
  logic [UW-1:0] a_val;
  logic [WW-1:0] w_op, b_op;
  logic signed [ACC_W-1:0] a_ext, w_ext, b_ext, prod, sum;

  // operand selection and the multiply-accumulate datapath
  always_comb begin
    out_layer = (cnt_h_q == HCW'(N_HID));
    first     = (cnt_i_q == '0);
    last      = out_layer ? (cnt_i_q == CW'(N_HID - 1)) : (cnt_i_q == CW'(N_IN - 1));
    waddr     = out_layer ? OWB + int'(cnt_i_q) : int'(cnt_h_q)*N_IN + int'(cnt_i_q);
    baddr     = out_layer ? OB : HB + int'(cnt_h_q);
    a_val     = out_layer ? hid_q[cnt_i_q[HIW-1:0]] : in_flat[cnt_i_q*UW +: UW];
    w_op      = w_flat[waddr*WW +: WW];
    b_op      = w_flat[baddr*WW +: WW];
    a_ext     = {{(ACC_W-UW){1'b0}}, a_val};
    w_ext     = {{(ACC_W-WW){w_op[WW-1]}}, w_op};
    b_ext     = {{(ACC_W-WW-UW){b_op[WW-1]}}, b_op, {UW{1'b0}}};
    prod      = a_ext * w_ext;
    sum       = (first ? b_ext : acc_q) + prod;
  end

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_i_d = cnt_i_q;
    cnt_h_d = cnt_h_q;
    acc_d   = acc_q;
    hid_d   = hid_q;
    thr_d   = thr_q;
    vld_d   = 1'b0;
    done    = 1'b0;
    if (phase_q == ST_COLLECT) begin
      if (start) begin
        phase_d = ST_EVAL;
        cnt_i_d = '0;
        cnt_h_d = '0;
      end
    end else begin
      acc_d = sum;
      if (last) begin
        cnt_i_d = '0;
        if (out_layer) begin
          thr_d   = act(sum);
          vld_d   = 1'b1;
          done    = 1'b1;
          phase_d = ST_COLLECT;
        end else begin
          for (int k = 0; k < N_HID; k++)
            if (cnt_h_q == HCW'(k)) hid_d[k] = act(sum);
          cnt_h_d = cnt_h_q + 1'b1;
        end
      end else begin
        cnt_i_d = cnt_i_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_COLLECT;
      cnt_i_q <= '0;
      cnt_h_q <= '0;
      acc_q   <= '0;
      for (int k = 0; k < N_HID; k++) hid_q[k] <= '0;
      thr_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_i_q <= cnt_i_d;
      cnt_h_q <= cnt_h_d;
      acc_q   <= acc_d;
      hid_q   <= hid_d;
      thr_q   <= thr_d;
      vld_q   <= vld_d;
    end
  end

  assign busy    = (phase_q == ST_EVAL);
  assign thr_vld = vld_q;
  assign thr_val = thr_q;
endmodule

// File: rtl/nn_thresh_pred.sv
module nn_thresh_pred #(
  parameter int N_IN    = 8,
  parameter int N_HID   = 4,
  parameter int UW      = 8,
  parameter int WW      = 6,
  parameter int ACT_SH  = 5,
  parameter int TIMEOUT = 64,
  localparam int NW     = N_IN*N_HID + 2*N_HID + 1,
  localparam int IW     = $clog2(N_IN),
  localparam int AW     = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          util_vld,
  input  logic [IW-1:0] util_sel,
  input  logic [UW-1:0] util_val,
  input  logic          wgt_we,
  input  logic [AW-1:0] wgt_addr,
  input  logic [WW-1:0] wgt_data,
  output logic          thr_vld,
  output logic [UW-1:0] thr_val
);
  logic               busy, done, start;
  logic [N_IN*UW-1:0] in_flat;
  logic [NW*WW-1:0]   w_flat;

  nn_collect #(.N_IN(N_IN), .UW(UW), .TIMEOUT(TIMEOUT)) collect_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clr(done),
    .u_valid(util_vld), .u_idx(util_sel), .u_data(util_val),
    .start(start), .in_flat(in_flat)
  );

  nn_wstore #(.NW(NW), .WW(WW)) wstore_i (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .wr_en(wgt_we), .wr_addr(wgt_addr), .wr_data(wgt_data),
    .w_flat(w_flat)
  );

  nn_seq #(.N_IN(N_IN), .N_HID(N_HID), .UW(UW), .WW(WW), .ACT_SH(ACT_SH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_flat(in_flat), .w_flat(w_flat),
    .busy(busy), .done(done), .thr_vld(thr_vld), .thr_val(thr_val)
  );
endmodule

// File: rtl/nn_thresh_pred_chk.sv
module nn_thresh_pred_chk #(
  parameter int N_IN  = 8,
  parameter int N_HID = 4,
  parameter int UW    = 8,
  parameter int WW    = 6,
  localparam int NW    = N_IN*N_HID + 2*N_HID + 1,
  localparam int STEPS = N_IN*N_HID + N_HID,
  localparam int CNTW  = $clog2(STEPS + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               thr_vld,
  input logic [UW-1:0]      thr_val,
  input logic               busy,
  input logic [NW*WW-1:0]   w_flat,
  input logic [N_IN*UW-1:0] in_flat
);
  logic [CNTW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (busy)    run_cnt <= run_cnt + 1'b1;
    else if (thr_vld) run_cnt <= '0;
  end

  assert_eval_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_vld |-> (run_cnt == CNTW'(STEPS)));

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    thr_vld |=> !thr_vld);

  assert_value_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_vld |-> $stable(thr_val));

  assert_samples_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(in_flat));

  assert_coef_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(w_flat));
endmodule

bind nn_thresh_pred nn_thresh_pred_chk #(
  .N_IN(N_IN), .N_HID(N_HID), .UW(UW), .WW(WW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .thr_vld(thr_vld), .thr_val(thr_val),
  .busy(busy), .w_flat(w_flat), .in_flat(in_flat)
);

// File: tb/nn_thresh_pred_tb_top.sv
module nn_thresh_pred_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO         = 40;

  logic       clk, rst_n;
  logic       util_vld, wgt_we, thr_vld;
  logic [2:0] util_sel;
  logic [7:0] util_val, thr_val;
  logic [5:0] wgt_addr, wgt_data;

  int tests, fails;
  int wm [41];
  int im [8];

  nn_thresh_pred #(.TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .util_vld(util_vld), .util_sel(util_sel),
    .util_val(util_val), .wgt_we(wgt_we), .wgt_addr(wgt_addr),
    .wgt_data(wgt_data), .thr_vld(thr_vld), .thr_val(thr_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int act(int s);
    int t;
    t = (s >>> 5) + 128;
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  function automatic int predict();
    int hv [4];
    int s;
    for (int h = 0; h < 4; h++) begin
      s = wm[32+h] * 256;
      for (int i = 0; i < 8; i++) s += wm[h*8+i] * im[i];
      hv[h] = act(s);
    end
    s = wm[40] * 256;
    for (int h = 0; h < 4; h++) s += wm[36+h] * hv[h];
    return act(s);
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(int a, int v);
    @(negedge clk);
    wgt_we = 1'b1; wgt_addr = 6'(a); wgt_data = 6'(v);
    @(negedge clk);
    wgt_we = 1'b0;
  endtask

  task automatic load();
    for (int a = 0; a < 41; a++) wr(a, wm[a]);
  endtask

  task automatic send(int i, int v);
    @(negedge clk);
    util_vld = 1'b1; util_sel = 3'(i); util_val = 8'(v);
    @(negedge clk);
    util_vld = 1'b0;
  endtask

  task automatic wait_vld(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!thr_vld && n < 1000);
  endtask

  task automatic check_pulse(int held);
    @(posedge clk); #1;
    check(!thr_vld, "R7 strobe length", int'(thr_vld), 0);
    check(int'(thr_val) == held, "R7 value held", int'(thr_val), held);
  endtask

  task automatic full_burst(string tag);
    int n, e;
    for (int i = 0; i < 8; i++) send(i, im[i]);
    wait_vld(n);
    e = predict();
    check(n == 36, "R2 latency", n, 36);
    check(int'(thr_val) == e, tag, int'(thr_val), e);
    check_pulse(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, e;
    tests = 0; fails = 0;
    rst_n = 1'b0; util_vld = 1'b0; util_sel = '0; util_val = '0;
    wgt_we = 1'b0; wgt_addr = '0; wgt_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!thr_vld, "R1 reset strobe", int'(thr_vld), 0);
    check(thr_val == 8'd0, "R1 reset value", int'(thr_val), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: all-zero coefficients give the midpoint
    for (int a = 0; a < 41; a++) wm[a] = 0;
    for (int i = 0; i < 8; i++) im[i] = 30*i + 5;
    full_burst("R1 zero coefficients");

    // R4/R5/R6 sweep over coefficient sets and input patterns
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 41; a++) begin
        if (k == 4)      wm[a] = 31;
        else if (k == 5) wm[a] = -32;
        else             wm[a] = ((a*7 + k*13 + 5 + (a*a*k) % 11) % 64) - 32;
      end
      load();
      wr(45, 17); // R6: out-of-map address ignored
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 8; i++) im[i] = (p == 3) ? 255 : (i*37 + p*91 + k*19 + 11) % 256;
        full_burst("R4/R5/R6 threshold");
      end
    end

    // R11: a repeated slot keeps its last value
    for (int a = 0; a < 41; a++) wm[a] = ((a*5 + 3) % 64) - 32;
    load();
    for (int i = 0; i < 8; i++) im[i] = (i*53 + 7) % 256;
    send(2, 99);
    send(2, 199);
    im[2] = 199;
    for (int i = 0; i < 8; i++) if (i != 2) send(i, im[i]);
    wait_vld(n);
    e = predict();
    check(int'(thr_val) == e, "R11 repeated slot", int'(thr_val), e);

    // R9 / R8: writes and samples during evaluation
    for (int i = 0; i < 8; i++) im[i] = (i*29 + 61) % 256;
    for (int i = 0; i < 8; i++) send(i, im[i]);
    wr(40, -20);
    wr(39, 25);
    send(0, 200);
    wait_vld(n);
    e = predict();
    check(int'(thr_val) == e, "R9 coefficients unchanged during evaluation", int'(thr_val), e);
    wm[39] = 25; // only the latest deferred write survives

    // R3 / R10 / R8: timeout burst with one sample, earlier slots cleared
    for (int i = 0; i < 8; i++) im[i] = 0;
    im[5] = 77;
    send(5, 77);
    wait_vld(n);
    e = predict();
    check(n == TO + 36, "R3 timeout latency", n, TO + 36);
    check(int'(thr_val) == e, "R3/R8/R9/R10 timeout result", int'(thr_val), e);
    check_pulse(e);

    // R3: partial burst with three samples
    for (int i = 0; i < 8; i++) im[i] = 0;
    im[1] = 250; im[4] = 13; im[7] = 180;
    send(1, 250); send(4, 13); send(7, 180);
    wait_vld(n);
    e = predict();
    check(n == TO + 36 - 4, "R3 partial latency", n, TO + 32);
    check(int'(thr_val) == e, "R3 partial burst", int'(thr_val), e);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule